// File: doc/BRIEF.md
# Single-Operand Shift and Extend Unit

This is a purely combinational datapath slice for the one-operand data operations of a 16-bit processor core. It has four operations, chosen by a 2-bit select. Arithmetic right shift keeps the sign bit in place. Right rotate through carry brings the incoming carry into the top bit. Byte swap exchanges the two halves of the operand. Sign extension spreads bit 7 across the upper byte.

The two shift operations follow the byte/word control. In byte mode they act on the low byte only, and the upper byte of the result is zero. Byte swap and sign extension always act on all 16 bits.

Alongside the result, the unit produces the four status flags (overflow, negative, zero, carry). Each flag has its own update enable, so the surrounding core can tell which status bits to write back. Byte swap asks for no flag update at all. Stack sequencing and operand addressing belong to other parts of the core.

Top module: `shift_ext_unit`

## Requirements
- R1: Select value 2'b00 is arithmetic right shift. In word mode (`byte_mode`=0) the result is {operand[15], operand[15:1]} and carry-out is operand[0].
- R2: In byte mode (`byte_mode`=1), both shifts work on operand[7:0] with bit 7 as the top bit. The result bits 15:8 are zero, and carry-out is operand[0].
- R3: Select value 2'b01 is rotate right through carry. In word mode the result is {carry_in, operand[15:1]} and carry-out is operand[0].
- R4: Rotate through carry in byte mode gives {8'h00, carry_in, operand[7:1]}.
- R5: The overflow flag is 0 for arithmetic shift. For rotate through carry it is 1 exactly when the operand's top bit (bit 7 in byte mode, bit 15 in word mode) is 0 and carry_in is 1.
- R6: For both shifts, the negative flag equals the result's top bit (bit 7 in byte mode, bit 15 in word mode), and the zero flag is 1 exactly when the result is zero.
- R7: Select value 2'b10 is byte swap. The result is {operand[7:0], operand[15:8]}, all four update enables are 0, and all four flag outputs are 0.
- R8: Select value 2'b11 is sign extension. The result is {8 copies of operand[7], operand[7:0]}. Overflow is 0, negative is result[15], zero is set on a zero result, and carry is the inverse of zero.
- R9: Byte swap and sign extension give the same result and flags whatever the value of `byte_mode`.
- R10: For both shifts and for sign extension, all four update enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation select (00 shift, 01 rotate, 10 swap, 11 extend) |
| byte_mode | input | 1 | 1 selects byte width for the shifts |
| operand | input | 16 | Source/destination value |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Operation result |
| flag_v | output | 1 | Overflow flag value |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| upd_v | output | 1 | Write enable for overflow |
| upd_n | output | 1 | Write enable for negative |
| upd_z | output | 1 | Write enable for zero |
| upd_c | output | 1 | Write enable for carry |

## Verification
The shifts are tried with operands whose top and bottom bits are both set. Such an operand shows whether the sign bit is kept or replaced by the carry, and whether the low bit reaches carry-out.

Each byte-mode shift uses an operand with a non-zero upper byte. That exposes an upper byte that was not cleared, or a top bit taken from position 15 instead of 7.

Rotate is driven with positive and negative operands and both carry values, which separates the overflow rule from the plain carry path. Sign extension uses a value that extends to zero and one with bit 7 set, so the inverted-zero carry is seen in both states. Swap and extend are each repeated with both `byte_mode` values to show that the control is ignored.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

   typedef enum logic [1:0] {
      OP_ASR  = 2'b00,
      OP_ROTC = 2'b01,
      OP_SWAP = 2'b10,
      OP_SEXT = 2'b11
   } sxu_op_e;

   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } sxu_flags_t;

endpackage

// File: rtl/sxu_shift.sv
module sxu_shift #(
   parameter int DATA_W      = 16,
   parameter bit CLEAR_UPPER = 1'b1
) (
   input  logic [DATA_W-1:0] operand,
   input  logic              byte_mode,
   input  logic              fill_bit,
   output logic [DATA_W-1:0] shifted,
   output logic              lsb_out
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] word_res;
   logic [DATA_W-1:0] byte_res;

   assign word_res = {fill_bit, operand[DATA_W-1:1]};
   assign lsb_out  = operand[0];

   generate
      if (CLEAR_UPPER) begin : g_clear_hi
         assign byte_res = {{HALF{1'b0}}, fill_bit, operand[HALF-1:1]};
      end else begin : g_keep_hi
         assign byte_res = {operand[DATA_W-1:HALF], fill_bit, operand[HALF-1:1]};
      end
   endgenerate

   assign shifted = byte_mode ? byte_res : word_res;

endmodule

// File: rtl/sxu_swap_ext.sv
module sxu_swap_ext #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] swapped,
   output logic [DATA_W-1:0] extended
);
   localparam int HALF = DATA_W / 2;

   assign swapped  = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
   assign extended = {{HALF{operand[HALF-1]}}, operand[HALF-1:0]};

endmodule

// File: rtl/sxu_flags.sv
module sxu_flags
   import sxu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  sxu_op_e           op,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] result,
   input  logic              carry_in,
   input  logic              lsb_in,
   output sxu_flags_t        flags,
   output sxu_flags_t        upd
);
   localparam int HALF = DATA_W / 2;

   logic narrow;
   logic res_top;
   logic opd_top;
   logic res_zero;

   always_comb begin
      narrow   = byte_mode && (op == OP_ASR || op == OP_ROTC);
      res_top  = narrow ? result[HALF-1]  : result[DATA_W-1];
      opd_top  = narrow ? operand[HALF-1] : operand[DATA_W-1];
      res_zero = narrow ? (result[HALF-1:0] == '0) : (result == '0);

      flags = '0;
      upd   = '0;
      case (op)
         OP_ASR: begin
            flags = '{v: 1'b0, n: res_top, z: res_zero, c: lsb_in};
            upd   = '1;
         end
         OP_ROTC: begin
            flags = '{v: (~opd_top) & carry_in, n: res_top, z: res_zero, c: lsb_in};
            upd   = '1;
         end
         OP_SEXT: begin
            flags = '{v: 1'b0, n: res_top, z: res_zero, c: ~res_zero};
            upd   = '1;
         end
         default: begin
            flags = '0;
            upd   = '0;
         end
      endcase
   end

endmodule

// File: rtl/shift_ext_unit.sv
module shift_ext_unit
   import sxu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit CLEAR_UPPER = 1'b1
) (
   input  logic [1:0]        op_sel,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] operand,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              flag_v,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              upd_v,
   output logic              upd_n,
   output logic              upd_z,
   output logic              upd_c
);
   localparam int HALF = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("shift_ext_unit: DATA_W must be even and at least 4");
      end
   endgenerate

   sxu_op_e           op;
   logic              fill;
   logic [DATA_W-1:0] shifted;
   logic              lsb;
   logic [DATA_W-1:0] swapped;
   logic [DATA_W-1:0] extended;
   sxu_flags_t        flags;
   sxu_flags_t        upd;

   assign op   = sxu_op_e'(op_sel);
   assign fill = (op == OP_ROTC) ? carry_in
               : (byte_mode ? operand[HALF-1] : operand[DATA_W-1]);

   sxu_shift #(.DATA_W(DATA_W), .CLEAR_UPPER(CLEAR_UPPER)) u_shift (
      .operand  (operand),
      .byte_mode(byte_mode),
      .fill_bit (fill),
      .shifted  (shifted),
      .lsb_out  (lsb)
   );

   sxu_swap_ext #(.DATA_W(DATA_W)) u_swap_ext (
      .operand (operand),
      .swapped (swapped),
      .extended(extended)
   );

   always_comb begin
      case (op)
         OP_SWAP: result = swapped;
         OP_SEXT: result = extended;
         default: result = shifted;
      endcase
   end

   sxu_flags #(.DATA_W(DATA_W)) u_flags (
      .op       (op),
      .byte_mode(byte_mode),
      .operand  (operand),
      .result   (result),
      .carry_in (carry_in),
      .lsb_in   (lsb),
      .flags    (flags),
      .upd      (upd)
   );

   assign flag_v = flags.v;
   assign flag_n = flags.n;
   assign flag_z = flags.z;
   assign flag_c = flags.c;
   assign upd_v  = upd.v;
   assign upd_n  = upd.n;
   assign upd_z  = upd.z;
   assign upd_c  = upd.c;

   // Cross-module checks between datapath outputs and flag logic
   always_comb begin
      if (!$isunknown({op_sel, byte_mode, operand, carry_in})) begin
         if (op == OP_ASR || op == OP_ROTC) begin
            p_carry_lsb_r1: assert (flag_c == operand[0])
               else $error("carry-out does not match operand bit 0");
         end
         if ((op == OP_ASR || op == OP_ROTC) && byte_mode && CLEAR_UPPER) begin
            p_byte_hi_clear_r2: assert (result[DATA_W-1:HALF] == '0)
               else $error("byte shift left upper byte non-zero");
         end
         if (op == OP_ROTC) begin
            p_rot_fill_r3: assert (result[byte_mode ? HALF-1 : DATA_W-1] == carry_in)
               else $error("rotate top bit is not carry_in");
         end
         if (flag_v && (op == OP_ROTC)) begin
            p_rot_v_r5: assert (carry_in)
               else $error("rotate overflow without carry_in");
         end
         if (op == OP_ASR) begin
            p_asr_no_v_r5: assert (!flag_v)
               else $error("arithmetic shift raised overflow");
         end
         if (op == OP_SWAP) begin
            p_swap_no_upd_r7: assert ({upd_v, upd_n, upd_z, upd_c} == 4'b0000)
               else $error("swap requested a flag update");
            p_swap_halves_r7: assert (result[HALF-1:0] == operand[DATA_W-1:HALF])
               else $error("swap low half wrong");
         end
         if (op == OP_SEXT) begin
            p_sext_c_r8: assert (flag_c == (result != '0))
               else $error("extend carry is not result non-zero");
         end
         if (op != OP_SWAP) begin
            p_upd_all_r10: assert ({upd_v, upd_n, upd_z, upd_c} == 4'b1111)
               else $error("flag update enables incomplete");
         end
      end
   end

endmodule

// File: tb/shift_ext_unit_tb.sv
module shift_ext_unit_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  op_sel;
   logic        byte_mode;
   logic [15:0] operand;
   logic        carry_in;
   logic [15:0] result;
   logic        flag_v, flag_n, flag_z, flag_c;
   logic        upd_v, upd_n, upd_z, upd_c;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   shift_ext_unit u_dut (
      .op_sel   (op_sel),
      .byte_mode(byte_mode),
      .operand  (operand),
      .carry_in (carry_in),
      .result   (result),
      .flag_v   (flag_v),
      .flag_n   (flag_n),
      .flag_z   (flag_z),
      .flag_c   (flag_c),
      .upd_v    (upd_v),
      .upd_n    (upd_n),
      .upd_z    (upd_z),
      .upd_c    (upd_c)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic bm,
                        input logic [15:0] val, input logic cin);
      @(posedge clk);
      op_sel    = op;
      byte_mode = bm;
      operand   = val;
      carry_in  = cin;
      @(negedge clk);
   endtask

   // flags packed as {v,n,z,c}
   function automatic logic [15:0] fl();
      return {12'h0, flag_v, flag_n, flag_z, flag_c};
   endfunction
   function automatic logic [15:0] en();
      return {12'h0, upd_v, upd_n, upd_z, upd_c};
   endfunction

   task automatic t_idle;
      apply(2'b00, 1'b0, 16'h0000, 1'b0);
      check("R6", "idle result", result, 16'h0000);
      check("R6", "idle flags z", fl(), 16'h0002);
   endtask

   task automatic t_asr_word;
      apply(2'b00, 1'b0, 16'h8001, 1'b0);
      check("R1", "asr word result", result, 16'hC000);
      check("R6", "asr word flags", fl(), 16'h0005);
      check("R10", "asr enables", en(), 16'h000F);
      apply(2'b00, 1'b0, 16'h0001, 1'b1);
      check("R1", "asr to zero result", result, 16'h0000);
      check("R6", "asr to zero flags", fl(), 16'h0003);
   endtask

   task automatic t_asr_byte;
      apply(2'b00, 1'b1, 16'h1281, 1'b0);
      check("R2", "asr byte result", result, 16'h00C0);
      check("R6", "asr byte flags", fl(), 16'h0005);
      apply(2'b00, 1'b1, 16'hF002, 1'b1);
      check("R2", "asr byte upper cleared", result, 16'h0001);
      check("R5", "asr byte flags v0", fl(), 16'h0000);
   endtask

   task automatic t_rotc_word;
      apply(2'b01, 1'b0, 16'h0002, 1'b1);
      check("R3", "rotc word result", result, 16'h8001);
      check("R5", "rotc positive cin flags", fl(), 16'h000C);
      apply(2'b01, 1'b0, 16'h8003, 1'b1);
      check("R3", "rotc negative result", result, 16'hC001);
      check("R5", "rotc negative flags", fl(), 16'h0005);
      apply(2'b01, 1'b0, 16'h0001, 1'b0);
      check("R6", "rotc zero flags", fl(), 16'h0003);
   endtask

   task automatic t_rotc_byte;
      apply(2'b01, 1'b1, 16'hAAFE, 1'b0);
      check("R4", "rotc byte result", result, 16'h007F);
      check("R5", "rotc byte neg op flags", fl(), 16'h0000);
      apply(2'b01, 1'b1, 16'h8011, 1'b1);
      check("R4", "rotc byte cin result", result, 16'h0088);
      check("R5", "rotc byte v flags", fl(), 16'h000D);
   endtask

   task automatic t_swap;
      for (int bm = 0; bm < 2; bm++) begin
         apply(2'b10, bm[0], 16'h12AB, 1'b1);
         check(bm ? "R9" : "R7", "swap result", result, 16'hAB12);
         check("R7", "swap enables", en(), 16'h0000);
         check("R7", "swap flags", fl(), 16'h0000);
      end
   endtask

   task automatic t_sext;
      for (int bm = 0; bm < 2; bm++) begin
         apply(2'b11, bm[0], 16'h1280, 1'b0);
         check(bm ? "R9" : "R8", "sext neg result", result, 16'hFF80);
         check("R8", "sext neg flags", fl(), 16'h0005);
         check("R10", "sext enables", en(), 16'h000F);
         apply(2'b11, bm[0], 16'hFF00, 1'b1);
         check(bm ? "R9" : "R8", "sext zero result", result, 16'h0000);
         check("R8", "sext zero flags", fl(), 16'h0002);
         apply(2'b11, bm[0], 16'h807F, 1'b0);
         check("R8", "sext pos result", result, 16'h007F);
         check("R8", "sext pos flags", fl(), 16'h0001);
      end
   endtask

   initial begin
      rst       = 1'b1;
      op_sel    = 2'b00;
      byte_mode = 1'b0;
      operand   = 16'h0000;
      carry_in  = 1'b0;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_asr_word();
      t_asr_byte();
      t_rotc_word();
      t_rotc_byte();
      t_swap();
      t_sext();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
   end

endmodule